// File: doc/BRIEF.md
# Processor Clock Throttle with Burst Pacing

This block produces the clock enable for an embedded microcontroller core so that the core can run well below the main system clock rate while the rest of the chip keeps full speed. A one-byte register selects the slowdown. In plain divided operation the core gets one enabled cycle out of every D system cycles, where D is a power of two from 4 to 1024. In burst pacing the core runs each instruction at full rate and then sits idle for exactly as long as needed to match the same average rate. During that idle stretch the block raises a standby flag. The memory interface uses this flag to keep every chip-select and the output-enable strobe inactive.

The core reports the last cycle of each instruction with a completion pulse. A new speed setting is taken only at such a boundary. A second register holds one enable bit per interrupt source. Any interrupt whose enable bit is set clears the speed register and puts the core back at full rate from the next cycle.

Top module: `cpu_clk_throttle`

## Requirements
- R1: After reset, both registers read 0, the core clock enable is 1 and the standby flag is 0.
- R2: A write to address 0 stores data bits 3..0 in the speed register. Bit 3 is the burst flag and bits 2..0 are the rate code. Reading address 0 returns these four bits with bits 7..4 always 0. Address 1 holds one interrupt-enable bit per source in its low bits, and the unused upper bits read 0.
- R3: Rate code 0 gives full speed. Codes 1 to 7 give division ratios 4, 8, 16, 64, 128, 512 and 1024. In non-burst operation the enable is high on exactly one cycle in every D system cycles, and that cycle is the last one of each D-cycle period counted from the instruction boundary.
- R4: A changed speed register takes effect only after a boundary, which is a cycle in which the completion pulse and the enable are both high. The new ratio's D-cycle count starts at that boundary.
- R5: With the burst flag set, an instruction that ran for n enabled cycles is followed by n*(D-1) idle cycles. The total is n*D cycles per instruction.
- R6: The standby flag is high exactly during burst idle cycles, and the enable is low whenever standby is high.
- R7: When an interrupt has its enable bit set, the next cycle shows a speed register of 0, an enable of 1 and a standby flag of 0, even in the middle of an idle stretch or a divided period.
- R8: An interrupt whose enable bit is clear changes neither the speed register nor the enable pattern.
- R9: If an enabled interrupt arrives in the same cycle as a write to the speed register, the interrupt wins and the register reads 0.
- R10: Burst flag set with rate code 0 gives full speed, with no idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 speed, 1 interrupt enables |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | input | N_IRQ | Interrupt request lines, one per source |
| instr_done | input | 1 | Core pulse on the last cycle of an instruction |
| core_ce | output | 1 | Clock enable for the core |
| mem_standby | output | 1 | Holds memory strobes inactive while high |

## Verification
Two functions can collide in one cycle. A software write to the speed register can arrive together with an unmasked interrupt that clears that register. Likewise, an interrupt exit can land on the same edge as an instruction boundary, or in the middle of a burst idle stretch. The bench drives these combinations on purpose. A behavioural model predicts the register value, the enable and the standby flag for every cycle, and the design is compared against it each clock, which shows whether the clear took priority and whether full speed resumed on the very next cycle.

// File: rtl/throttle_pkg.sv
// Shared types and helpers for the core clock throttle.
// Assumes rate codes are three bits wide and the largest ratio is 2**10.
package throttle_pkg;

    localparam int MAX_SHIFT = 10;

    typedef struct packed {
        logic       burst;
        logic [2:0] code;
    } speed_t;

    // Map a rate code to log2 of its division ratio.
    function automatic logic [3:0] code_shift(input logic [2:0] code);
        logic [3:0] sh;
        case (code)
            3'd1:    sh = 4'd2;
            3'd2:    sh = 4'd3;
            3'd3:    sh = 4'd4;
            3'd4:    sh = 4'd6;
            3'd5:    sh = 4'd7;
            3'd6:    sh = 4'd9;
            3'd7:    sh = 4'd10;
            default: sh = 4'd0;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/thr_regs.sv
// Register file of the throttle: the speed register and the interrupt enables.
// An enabled interrupt clears the speed register and outranks a write in the
// same cycle. Assumes N_IRQ is 8 or less.
module thr_regs
    import throttle_pkg::*;
#(
    parameter int N_IRQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic [N_IRQ-1:0] irq,
    output speed_t           speed,
    output logic [7:0]       reg_rdata,
    output logic             exit_req
);

    localparam int PAD_W = 8 - N_IRQ;

    speed_t           speed_q;
    logic [N_IRQ-1:0] ien_q;

    assign exit_req = |(irq & ien_q);
    assign speed    = speed_q;

    // Speed register: interrupt exit clears it, otherwise a write loads it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            speed_q <= '0;
        else if (exit_req)
            speed_q <= '0;
        else if (reg_wr && !reg_addr)
            speed_q <= speed_t'(reg_wdata[3:0]);
    end

    // Interrupt enable register: plain load on write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien_q <= '0;
        else if (reg_wr && reg_addr)
            ien_q <= reg_wdata[N_IRQ-1:0];
    end

    // Read mux: unused bits read as zero.
    always_comb begin
        if (reg_addr)
            reg_rdata = {{PAD_W{1'b0}}, ien_q};
        else
            reg_rdata = {4'b0000, speed_q};
    end

    p_exit_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |=> (speed_q == '0));

    p_masked_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!exit_req && !(reg_wr && !reg_addr)) |=> $stable(speed_q));

endmodule

// File: rtl/thr_pacer.sv
// Clock enable pacer: a divided period counter for plain mode, plus a run and
// idle counter for burst mode. The speed setting is taken only at instruction
// boundaries. Assumes instr_done means something only while core_ce is high.
module thr_pacer
    import throttle_pkg::*;
#(
    parameter int RUN_W = 6
) (
    input  logic   clk,
    input  logic   rst_n,
    input  speed_t speed,
    input  logic   exit_req,
    input  logic   instr_done,
    output logic   core_ce,
    output logic   mem_standby
);

    localparam int IDLE_W = RUN_W + MAX_SHIFT + 1;

    logic [3:0]           sh_q;
    logic                 burst_q;
    logic [MAX_SHIFT-1:0] div_q;
    logic [RUN_W-1:0]     run_q;
    logic [IDLE_W-1:0]    idle_q;

    logic [MAX_SHIFT:0]   ratio;
    logic [MAX_SHIFT:0]   lim_w;
    logic [MAX_SHIFT-1:0] div_lim;
    logic [IDLE_W-1:0]    n_ext;
    logic [IDLE_W-1:0]    idle_load;
    logic                 boundary;
    logic                 idling;

    // Ratio and the last count of the current period.
    always_comb begin
        ratio   = (MAX_SHIFT+1)'(1) << sh_q;
        lim_w   = ratio - (MAX_SHIFT+1)'(1);
        div_lim = lim_w[MAX_SHIFT-1:0];
    end

    // Burst idle length: n*(D-1), where n is the number of cycles just run.
    always_comb begin
        n_ext     = IDLE_W'(run_q) + IDLE_W'(1);
        idle_load = (n_ext << sh_q) - n_ext;
    end

    assign idling      = (idle_q != '0);
    assign boundary    = instr_done && core_ce;
    assign mem_standby = idling;

    // Enable decode: held off while idle, free-running in full or burst mode.
    always_comb begin
        if (idling)
            core_ce = 1'b0;
        else if (burst_q || sh_q == 4'd0)
            core_ce = 1'b1;
        else
            core_ce = (div_q == div_lim);
    end

    // Active setting: loaded at boundaries, cleared on interrupt exit.
    always_ff @(posedge clk) begin
        if (!rst_n || exit_req) begin
            sh_q    <= '0;
            burst_q <= 1'b0;
        end else if (boundary) begin
            sh_q    <= code_shift(speed.code);
            burst_q <= speed.burst;
        end
    end

    // Period, run and idle counters.
    always_ff @(posedge clk) begin
        if (!rst_n || exit_req) begin
            div_q  <= '0;
            run_q  <= '0;
            idle_q <= '0;
        end else if (boundary) begin
            div_q  <= '0;
            run_q  <= '0;
            idle_q <= burst_q ? idle_load : '0;
        end else if (idling) begin
            idle_q <= idle_q - IDLE_W'(1);
        end else begin
            div_q <= (div_q == div_lim) ? '0 : div_q + MAX_SHIFT'(1);
            if (core_ce && run_q != '1)
                run_q <= run_q + RUN_W'(1);
        end
    end

    p_standby_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_standby |-> !core_ce);

    p_exit_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |=> (core_ce && !mem_standby));

    p_idle_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idling && !exit_req) |=> (idle_q == $past(idle_q) - IDLE_W'(1)));

    p_apply_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary && !exit_req) |=> ($stable(sh_q) && $stable(burst_q)));

    p_full_speed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q == 4'd0 && !idling) |-> core_ce);

endmodule

// File: rtl/cpu_clk_throttle.sv
// Top of the core clock throttle: register file plus pacer.
// Assumes the core is clocked by clk qualified with core_ce, and that the
// memory strobes are forced inactive while mem_standby is high.
module cpu_clk_throttle
    import throttle_pkg::*;
#(
    parameter int N_IRQ = 4,
    parameter int RUN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [N_IRQ-1:0] irq,
    input  logic             instr_done,
    output logic             core_ce,
    output logic             mem_standby
);

    speed_t speed;
    logic   exit_req;

    thr_regs #(.N_IRQ(N_IRQ)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .irq       (irq),
        .speed     (speed),
        .reg_rdata (reg_rdata),
        .exit_req  (exit_req)
    );

    thr_pacer #(.RUN_W(RUN_W)) u_pacer (
        .clk         (clk),
        .rst_n       (rst_n),
        .speed       (speed),
        .exit_req    (exit_req),
        .instr_done  (instr_done),
        .core_ce     (core_ce),
        .mem_standby (mem_standby)
    );

endmodule

// File: tb/cpu_clk_throttle_test.sv
module cpu_clk_throttle_test;

    localparam int CLK_PERIOD = 10;
    localparam int N_IRQ      = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic             reg_addr = 1'b0;
    logic [7:0]       reg_wdata = '0;
    logic [7:0]       reg_rdata;
    logic [N_IRQ-1:0] irq = '0;
    logic             instr_done = 1'b0;
    logic             core_ce;
    logic             mem_standby;

    int vectors = 0;
    int errors  = 0;

    // Reference model state.
    int m_speed = 0, m_ien = 0, m_shift = 0, m_burst = 0;
    int m_div = 0, m_run = 0, m_idle = 0, m_addr = 0;

    // Core emulation: instruction lengths in enabled cycles.
    int lens[5] = '{1, 3, 2, 4, 1};
    int li = 0;
    int rem = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_clk_throttle #(.N_IRQ(N_IRQ), .RUN_W(6)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .instr_done(instr_done), .core_ce(core_ce), .mem_standby(mem_standby)
    );

    function automatic int shift_of(input int code);
        case (code & 7)
            1: return 2;  2: return 3;  3: return 4;  4: return 6;
            5: return 7;  6: return 9;  7: return 10; default: return 0;
        endcase
    endfunction

    task automatic check(input string rq, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", rq, what, act, exp, $time);
        end
    endtask

    // One cycle: compare at the negedge, drive inputs, advance the model.
    task automatic step(input bit wr, input bit ad, input int wd, input int iq, input string rq);
        int  e_ce, e_sb, e_rd, d, exitv;
        bit  done;
        @(negedge clk);
        d    = 1 << m_shift;
        e_sb = (m_idle > 0);
        if (m_idle > 0)                   e_ce = 0;
        else if (m_burst || m_shift == 0) e_ce = 1;
        else                              e_ce = (m_div == d - 1);
        e_rd = m_addr ? m_ien : m_speed;
        check(rq, "core_ce", int'(core_ce), e_ce);
        check(rq, "mem_standby", int'(mem_standby), e_sb);
        check(rq, "reg_rdata", int'(reg_rdata), e_rd);
        // Core emulator: pulse completion on the last enabled cycle.
        done = 1'b0;
        if (e_ce == 1) begin
            if (rem == 1) begin
                done = 1'b1;
                li   = (li + 1) % 5;
                rem  = lens[li];
            end else begin
                rem--;
            end
        end
        instr_done = done;
        reg_wr     = wr;
        reg_addr   = ad;
        reg_wdata  = 8'(wd);
        irq        = N_IRQ'(iq);
        // Model advance for the coming posedge.
        exitv  = ((iq & m_ien) != 0);
        m_addr = ad;
        if (exitv) begin
            m_speed = 0; m_shift = 0; m_burst = 0;
            m_div = 0; m_run = 0; m_idle = 0;
        end else if (done && e_ce == 1) begin
            m_idle  = m_burst ? (m_run + 1) * (d - 1) : 0;
            m_shift = shift_of(m_speed);
            m_burst = (m_speed >> 3) & 1;
            m_div = 0; m_run = 0;
        end else if (m_idle > 0) begin
            m_idle--;
        end else begin
            if (e_ce == 1 && m_run < 63) m_run++;
            m_div = (m_div + 1) % d;
        end
        if (wr && !ad && !exitv) m_speed = wd & 15;
        if (wr && ad)            m_ien   = wd & ((1 << N_IRQ) - 1);
    endtask

    task automatic idle_run(input int n, input string rq);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, rq);
    endtask

    task automatic wr_speed(input int v, input string rq);
        step(1, 0, v, 0, rq);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state out of reset.
        idle_run(4, "R1");
        // R2: readback and unused bits.
        wr_speed(8'hA0, "R2");
        idle_run(2, "R2");
        wr_speed(8'hF5, "R2");
        idle_run(2, "R2");
        wr_speed(8'h00, "R2");
        step(1, 1, 8'hFF, 0, "R2");
        idle_run(2, "R2");
        step(1, 1, 8'h02, 0, "R2");
        step(0, 1, 0, 0, "R2");
        // R3/R4: divided ratios, effective at boundaries.
        wr_speed(8'h01, "R4");
        idle_run(60, "R3");
        wr_speed(8'h02, "R4");
        idle_run(120, "R3");
        wr_speed(8'h04, "R4");
        idle_run(700, "R3");
        wr_speed(8'h07, "R4");
        idle_run(5000, "R3");
        wr_speed(8'h03, "R4");
        idle_run(1200, "R3");
        // R5/R6: burst pacing with standby.
        wr_speed(8'h09, "R5");
        idle_run(300, "R5");
        wr_speed(8'h0B, "R6");
        idle_run(600, "R6");
        // R8: masked interrupt during idle.
        step(0, 0, 0, 1, "R8");
        step(0, 0, 0, 8, "R8");
        idle_run(200, "R8");
        // R7: enabled interrupt mid-idle.
        step(0, 0, 0, 2, "R7");
        idle_run(5, "R7");
        // R7: exit during a divided period.
        wr_speed(8'h05, "R7");
        idle_run(300, "R7");
        step(0, 0, 0, 2, "R7");
        idle_run(5, "R7");
        // R9: write and exit in the same cycle.
        wr_speed(8'h0C, "R9");
        idle_run(100, "R9");
        step(1, 0, 8'h0A, 2, "R9");
        idle_run(10, "R9");
        // R10: burst flag with full-speed code.
        wr_speed(8'h08, "R10");
        idle_run(40, "R10");
        wr_speed(8'h00, "R10");
        idle_run(10, "R10");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule